// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits between a microcontroller's peripherals and its CPU core. It gathers request flags from three classes of source: reset causes, non-maskable events and ordinary maskable interrupts. Each cycle it chooses the most urgent request that is allowed to fire and presents that request's 16-bit vector-table address. The vector table occupies the top 64 bytes of the address space. Reset has the highest-priority entry, the non-maskable group has the next entry down, and the maskable slots descend two bytes per priority step.

The controller also checks the CPU's instruction fetches. A fetch from the peripheral register window or from an unpopulated address hole raises a system reset request. Data accesses to those addresses are left alone. When the word read from the reset vector after power-up is all ones (an erased, unprogrammed table), the controller asks the core to drop into its lowest-power state instead of starting execution. When the CPU acknowledges an interrupt, the chosen vector is held in a register. If that interrupt is maskable, a one-cycle strobe tells the core to clear its global enable, so that interrupts do not nest unless software allows it.

Top module: `irq_vector_ctrl`

## Requirements
- R1: When any bit of `rst_cause` is set, `irq_req` and `sys_rst_req` are 1 and `vec_addr` is 16'hFFFE in the same cycle, whatever the other inputs are.
- R2: When no reset cause is set and any bit of `nmi_flag` is set together with the same bit of `nmi_en`, `irq_req` is 1 and `vec_addr` is 16'hFFFC, independent of `gie`.
- R3: Maskable slot i (bit i of `irq_flag`/`irq_en`, priority 14+i) requests vector 16'hFFDC + 2*i only when its flag, its enable and `gie` are all 1. When `gie` is 0, or when the slot's own enable is 0, the slot requests nothing.
- R4: When several requests are allowed at once, `vec_addr` belongs to the highest one: reset over non-maskable, non-maskable over maskable, and a higher slot index over a lower one.
- R5: Slot 6 (vector 16'hFFE8) has no source and is never selected, even when its flag and enable are set. With no allowed request, `irq_req` is 0 and `vec_addr` is 16'h0000.
- R6: A fetch with `fetch_valid`=1 and `fetch_addr` in 16'h0000–16'h01FF, or in the unused hole HOLE_LO–HOLE_HI (default 16'h2100–16'h30FF), makes `sys_rst_req` 1 in the next cycle only. The same addresses with `fetch_valid`=0 raise no reset.
- R7: A `rst_vec_valid` strobe with `rst_vec_word` = 16'hFFFF sets `lpm_req` from the next cycle on. A strobe with any other word clears it.
- R8: When `ack` is 1 and `irq_req` is 1 at a clock edge, `vec_latched` takes the current `vec_addr` after that edge. `gie_clr` pulses for exactly that one cycle if the acknowledged vector is maskable (below 16'hFFFC), and stays 0 for the reset and non-maskable vectors.
- R9: After reset, `vec_latched` is 16'h0000 and `lpm_req`, `gie_clr` and the fetch-caused reset are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_cause | input | 5 | Reset-cause flags |
| nmi_flag | input | 3 | Non-maskable source flags |
| nmi_en | input | 3 | Per-source enables for the non-maskable sources |
| irq_flag | input | 16 | Maskable request flags, one per slot |
| irq_en | input | 16 | Maskable per-slot enables |
| gie | input | 1 | Global interrupt enable |
| fetch_valid | input | 1 | Marks `fetch_addr` as an instruction fetch |
| fetch_addr | input | 16 | CPU access address |
| rst_vec_valid | input | 1 | Strobe: `rst_vec_word` holds the reset vector |
| rst_vec_word | input | 16 | Word read from the reset vector |
| ack | input | 1 | CPU acknowledges the current request |
| irq_req | output | 1 | An allowed request is pending |
| vec_addr | output | 16 | Vector address of the winning request |
| vec_latched | output | 16 | Vector captured at the last acknowledge |
| gie_clr | output | 1 | One-cycle strobe to clear the global enable |
| sys_rst_req | output | 1 | System reset request |
| lpm_req | output | 1 | Request for the lowest-power state |

## Verification
The bench checks the priority order with several requests set at once. An inverted or truncated encoder would give a lower vector. It sets `gie` to 0 while non-maskable and maskable flags are pending. A design that gated the non-maskable group with the global enable would drop FFFC, and one that ignored it would leak maskable vectors. It sets only the flag and enable of slot 6. It also probes fetches at the window edges 16'h01FF and 16'h0200 and repeats them without `fetch_valid`. A wrong comparison bound or a missing strobe check would either miss the reset or raise a false one. Finally it acknowledges a maskable and a non-maskable request to make sure `gie_clr` fires only for the first.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NSLOT = 16,
  parameter logic [15:0] HOLE_LO = 16'h2100,
  parameter logic [15:0] HOLE_HI = 16'h30FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  rst_cause,
  input  logic [2:0]  nmi_flag,
  input  logic [2:0]  nmi_en,
  input  logic [15:0] irq_flag,
  input  logic [15:0] irq_en,
  input  logic        gie,
  input  logic        fetch_valid,
  input  logic [15:0] fetch_addr,
  input  logic        rst_vec_valid,
  input  logic [15:0] rst_vec_word,
  input  logic        ack,
  output logic        irq_req,
  output logic [15:0] vec_addr,
  output logic [15:0] vec_latched,
  output logic        gie_clr,
  output logic        sys_rst_req,
  output logic        lpm_req
);
  localparam logic [15:0] VEC_RST  = 16'hFFFE;
  localparam logic [15:0] VEC_NMI  = 16'hFFFC;
  localparam logic [15:0] VEC_BASE = 16'hFFDC;
  localparam logic [15:0] EMPTY    = 16'h0040;

  logic        rst_hit, nmi_hit, mask_hit, bad_fetch, fetch_rst_q;
  logic [15:0] live;
  logic [15:0] mask_vec;

  assign live     = irq_flag & irq_en & ~EMPTY & {16{gie}};
  assign rst_hit  = |rst_cause;
  assign nmi_hit  = |(nmi_flag & nmi_en);
  assign mask_hit = |live;

  always_comb begin
    mask_vec = 16'h0000;
    for (int i = 0; i < NSLOT; i++)
      if (live[i]) mask_vec = VEC_BASE + 16'(2 * i);
  end

  assign irq_req  = rst_hit | nmi_hit | mask_hit;
  assign vec_addr = rst_hit ? VEC_RST : nmi_hit ? VEC_NMI : mask_vec;

  assign bad_fetch = fetch_valid &&
                     (fetch_addr < 16'h0200 || (fetch_addr >= HOLE_LO && fetch_addr <= HOLE_HI));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fetch_rst_q <= 1'b0;
      lpm_req     <= 1'b0;
      vec_latched <= 16'h0000;
      gie_clr     <= 1'b0;
    end else begin
      fetch_rst_q <= bad_fetch;
      if (rst_vec_valid) lpm_req <= (rst_vec_word == 16'hFFFF);
      gie_clr <= 1'b0;
      if (ack && irq_req) begin
        vec_latched <= vec_addr;
        gie_clr     <= !rst_hit && !nmi_hit;
      end
    end

  assign sys_rst_req = rst_hit | fetch_rst_q;

  always_comb begin
    if (rst_n && irq_req)
      assert_vec_in_table_R4: assert (vec_addr[15:6] == 10'h3FF && !vec_addr[0]);
    if (rst_n)
      assert_slot_empty_R5: assert (vec_addr != 16'hFFE8);
  end

  assert_gie_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie && !rst_hit && !(|(nmi_flag & nmi_en))) |-> !irq_req);

  assert_fetch_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_addr < 16'h0200) |=> sys_rst_req);

  assert_lpm_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_vec_valid && rst_vec_word == 16'hFFFF) |=> lpm_req);

  assert_clr_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |-> $past(ack));

  assert_nmi_no_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && nmi_hit) |=> !gie_clr);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  // {rst_cause, nmi_flag, nmi_en, irq_flag, irq_en, gie, exp_req, exp_vec}
  localparam logic [60:0] VTAB [NV] = '{
    {5'b00000, 3'b000, 3'b000, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h0000},
    {5'b00100, 3'b111, 3'b111, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 16'hFFFE},
    {5'b00000, 3'b010, 3'b010, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 16'hFFFC},
    {5'b00000, 3'b010, 3'b101, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h0000},
    {5'b00000, 3'b000, 3'b000, 16'h8001, 16'hFFFF, 1'b1, 1'b1, 16'hFFFA},
    {5'b00000, 3'b000, 3'b000, 16'h0001, 16'h0001, 1'b1, 1'b1, 16'hFFDC},
    {5'b00000, 3'b000, 3'b000, 16'h0021, 16'h0021, 1'b0, 1'b0, 16'h0000},
    {5'b00000, 3'b000, 3'b000, 16'h0041, 16'h0041, 1'b1, 1'b1, 16'hFFDC},
    {5'b00000, 3'b000, 3'b000, 16'h00A0, 16'h0020, 1'b1, 1'b1, 16'hFFE6}
  };

  logic clk = 0, rst_n = 0;
  logic [4:0] rst_cause = 0;
  logic [2:0] nmi_flag = 0, nmi_en = 0;
  logic [15:0] irq_flag = 0, irq_en = 0, fetch_addr = 16'h8000, rst_vec_word = 0;
  logic gie = 0, fetch_valid = 0, rst_vec_valid = 0, ack = 0;
  logic irq_req, gie_clr, sys_rst_req, lpm_req;
  logic [15:0] vec_addr, vec_latched;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl u0 (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    rst_cause = 0; nmi_flag = 0; nmi_en = 0; irq_flag = 0; irq_en = 0;
    gie = 0; fetch_valid = 0; fetch_addr = 16'h8000; rst_vec_valid = 0; ack = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R9 vec_latched", vec_latched, 16'h0000);
    chk("R9 lpm_req", 16'(lpm_req), 16'h0);
    chk("R9 gie_clr", 16'(gie_clr), 16'h0);
    chk("R9 sys_rst_req", 16'(sys_rst_req), 16'h0);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      {rst_cause, nmi_flag, nmi_en, irq_flag, irq_en, gie} = VTAB[k][60:17];
      #1;
      chk($sformatf("R1-R5 table %0d req", k), 16'(irq_req), 16'(VTAB[k][16]));
      chk($sformatf("R4 table %0d vec", k), vec_addr, VTAB[k][15:0]);
      @(negedge clk);
    end
    clear_in();

    rst_cause = 5'b10000; #1;
    chk("R1 sys_rst_req from cause", 16'(sys_rst_req), 16'h1);
    clear_in();

    irq_flag = 16'h0040; irq_en = 16'h0040; gie = 1; #1;
    chk("R5 empty slot req", 16'(irq_req), 16'h0);
    chk("R5 empty slot vec", vec_addr, 16'h0000);
    clear_in();

    fetch_valid = 1; fetch_addr = 16'h01FF;
    @(negedge clk);
    chk("R6 fetch 01FF reset", 16'(sys_rst_req), 16'h1);
    fetch_addr = 16'h0200;
    @(negedge clk);
    chk("R6 fetch 0200 no reset", 16'(sys_rst_req), 16'h0);
    fetch_addr = 16'h2100;
    @(negedge clk);
    chk("R6 fetch hole low", 16'(sys_rst_req), 16'h1);
    fetch_addr = 16'h3100;
    @(negedge clk);
    chk("R6 fetch past hole", 16'(sys_rst_req), 16'h0);
    fetch_valid = 0; fetch_addr = 16'h0010;
    @(negedge clk);
    chk("R6 data access no reset", 16'(sys_rst_req), 16'h0);
    clear_in();

    rst_vec_valid = 1; rst_vec_word = 16'hFFFF;
    @(negedge clk);
    rst_vec_valid = 0;
    @(negedge clk);
    chk("R7 lpm set and held", 16'(lpm_req), 16'h1);
    rst_vec_valid = 1; rst_vec_word = 16'h8000;
    @(negedge clk);
    rst_vec_valid = 0;
    chk("R7 lpm cleared", 16'(lpm_req), 16'h0);

    irq_flag = 16'h0100; irq_en = 16'h0100; gie = 1; ack = 1;
    @(negedge clk);
    ack = 0;
    chk("R8 latched maskable", vec_latched, 16'hFFEC);
    chk("R8 gie_clr pulse", 16'(gie_clr), 16'h1);
    @(negedge clk);
    chk("R8 gie_clr one cycle", 16'(gie_clr), 16'h0);
    clear_in();

    nmi_flag = 3'b100; nmi_en = 3'b100; ack = 1;
    @(negedge clk);
    ack = 0;
    chk("R8 latched nmi", vec_latched, 16'hFFFC);
    chk("R8 no gie_clr for nmi", 16'(gie_clr), 16'h0);
    clear_in();
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule